// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block runs the multi-word programming path of a flash command interface. A host writes a setup command, then a count word that says how many data words follow. It then writes those data words, which the block stages in a 32-word on-chip buffer. A final confirm write starts one array operation that commits every staged word at once. Status bit 7 reports readiness. It reads 0 while a commit is in progress, so a host that issued setup and sees bit 7 cleared issues setup again and polls.

All staged words must fall inside one 32-word aligned window, chosen by the address of the count write. Sequence errors, an oversized count, a locked target and a bad programming supply each set a sticky error bit. They return the block to idle and leave the array unchanged. Programming only clears bits: each committed word becomes the bitwise AND of the old contents and the new data. The array model is included so that the effect of a commit can be read back through a simple read port.

Top module: `wbp_seq`

## Requirements
- R1: After reset, status reads 0x80 and every array word reads all ones.
- R2: In idle, a write whose data low byte is 0xE8 (setup) is accepted, and status bit 7 stays 1. The next write is taken as the count.
- R3: The count word is N-1 for N data words. A count value above 31 sets status bit 4 (program fail), returns to idle and leaves the array unchanged.
- R4: A data write whose address is outside the 32-word aligned window of the count address sets bit 4 and returns to idle without programming.
- R5: After N data words, a write with data low byte 0xD0 (confirm) starts the commit. Any other write sets bit 4 and returns to idle.
- R6: The commit keeps status bit 7 at 0 for COMMIT_CYCLES cycles, then returns it to 1.
- R7: At the end of the commit, each written buffer offset updates its array word to the old value AND the new data. Offsets that were not written are left unchanged.
- R8: If blk_lock is high at confirm, status bit 1 is set, the block returns to idle and the array is left unchanged.
- R9: If supply_ok is low at confirm, status bit 3 is set, the block returns to idle and the array is left unchanged.
- R10: In idle, a write with data low byte 0x50 clears status bits 4, 3 and 1.
- R11: Writes made during a commit, including setup, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | AW | Word address of the host write |
| wr_data | input | DW | Host write data: a command code in the low byte, a count, or a data word |
| blk_lock | input | 1 | Target block is locked, sampled at confirm |
| supply_ok | input | 1 | Programming supply is valid, sampled at confirm |
| status | output | 8 | Bit 7 ready, bit 4 program fail, bit 3 supply error, bit 1 lock error |
| rd_addr | input | AW | Array read address |
| rd_data | output | DW | Array word at rd_addr |

## Verification
The assertions check the sequencing rules on every cycle. A commit can only be entered from a confirm with the lock clear and the supply valid. An oversized count or an out-of-window write forces idle with the fail bit set. The remaining-word count stays between 1 and 32 while loading, and a commit that is still counting stays busy. Only the bench scenarios can show the array contents: the AND merge, unwritten offsets left alone, and rejected sequences leaving words erased. They also show that writes made during a commit, including a retried setup, leave no trace in later behaviour.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_LOAD,
    ST_CONFIRM,
    ST_COMMIT
  } wbp_state_t;

  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;

  localparam int SB_READY  = 7;
  localparam int SB_FAIL   = 4;
  localparam int SB_SUPPLY = 3;
  localparam int SB_LOCK   = 1;
endpackage

// File: rtl/wbp_ctrl.sv
module wbp_ctrl
  import wbp_pkg::*;
#(
  parameter int AW            = 7,
  parameter int DW            = 16,
  parameter int BUF_WORDS     = 32,
  parameter int COMMIT_CYCLES = 8,
  localparam int OFF_W        = $clog2(BUF_WORDS),
  localparam int WIN_W        = AW - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             blk_lock,
  input  logic             supply_ok,
  output logic             buf_clr,
  output logic             buf_we,
  output logic             commit_go,
  output logic [WIN_W-1:0] win,
  output logic [7:0]       status
);
  localparam int REM_W = OFF_W + 1;
  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

  wbp_state_t       state_q, state_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fail_q, fail_d, sup_q, sup_d, lock_q, lock_d;
  logic [7:0]       cmd;
  logic             in_win;

  assign cmd    = wr_data[7:0];
  assign in_win = (wr_addr[AW-1:OFF_W] == win_q);

  always_comb begin
    state_d   = state_q;
    rem_d     = rem_q;
    win_d     = win_q;
    cnt_d     = cnt_q;
    fail_d    = fail_q;
    sup_d     = sup_q;
    lock_d    = lock_q;
    buf_clr   = 1'b0;
    buf_we    = 1'b0;
    commit_go = 1'b0;
    case (state_q)
      ST_IDLE: if (wr_en) begin
        if (cmd == CMD_SETUP) begin
          state_d = ST_COUNT;
        end else if (cmd == CMD_CLEAR) begin
          fail_d = 1'b0;
          sup_d  = 1'b0;
          lock_d = 1'b0;
        end
      end
      ST_COUNT: if (wr_en) begin
        if (wr_data > DW'(BUF_WORDS - 1)) begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          rem_d   = wr_data[REM_W-1:0] + REM_W'(1);
          win_d   = wr_addr[AW-1:OFF_W];
          buf_clr = 1'b1;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: if (wr_en) begin
        if (!in_win) begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          buf_we = 1'b1;
          rem_d  = rem_q - REM_W'(1);
          if (rem_q == REM_W'(1)) state_d = ST_CONFIRM;
        end
      end
      ST_CONFIRM: if (wr_en) begin
        if (cmd == CMD_CONFIRM) begin
          if (blk_lock)   lock_d = 1'b1;
          if (!supply_ok) sup_d  = 1'b1;
          if (!blk_lock && supply_ok) begin
            cnt_d   = CNT_W'(COMMIT_CYCLES - 1);
            state_d = ST_COMMIT;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_COMMIT: begin
        if (cnt_q == '0) begin
          commit_go = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      win_q   <= '0;
      cnt_q   <= '0;
      fail_q  <= 1'b0;
      sup_q   <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      win_q   <= win_d;
      cnt_q   <= cnt_d;
      fail_q  <= fail_d;
      sup_q   <= sup_d;
      lock_q  <= lock_d;
    end
  end

  assign win    = win_q;
  assign status = {state_q != ST_COMMIT, 2'b00, fail_q, sup_q, 1'b0, lock_q, 1'b0};

  assert_commit_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMMIT && $past(state_q) == ST_CONFIRM) |->
      $past(wr_en && wr_data[7:0] == CMD_CONFIRM && !blk_lock && supply_ok));

  assert_oversize_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && wr_en && wr_data > DW'(BUF_WORDS - 1)) |=>
      (state_q == ST_IDLE && status[SB_FAIL]));

  assert_remaining_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD) |-> (rem_q != '0 && rem_q <= REM_W'(BUF_WORDS)));

  assert_window_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && wr_en && !in_win) |=> (state_q == ST_IDLE && status[SB_FAIL]));

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMMIT && cnt_q != '0) |=> (state_q == ST_COMMIT && !status[SB_READY]));
endmodule

// File: rtl/wbp_buffer.sv
module wbp_buffer #(
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  localparam int OFF_W    = $clog2(BUF_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 we,
  input  logic [OFF_W-1:0]     off,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        buf_data [BUF_WORDS],
  output logic [BUF_WORDS-1:0] buf_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= '0;
    end else if (clr) begin
      buf_valid <= '0;
    end else if (we) begin
      buf_valid[off] <= 1'b1;
    end
  end

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && off == OFF_W'(g)) buf_data[g] <= wdata;
    end
  end
endmodule

// File: rtl/wbp_array.sv
module wbp_array #(
  parameter int AW        = 7,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  localparam int OFF_W    = $clog2(BUF_WORDS),
  localparam int WIN_W    = AW - OFF_W,
  localparam int DEPTH    = 1 << AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [WIN_W-1:0]     win,
  input  logic [DW-1:0]        buf_data [BUF_WORDS],
  input  logic [BUF_WORDS-1:0] buf_valid,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit) begin
      for (int j = 0; j < BUF_WORDS; j++) begin
        if (buf_valid[j]) mem[{win, OFF_W'(j)}] <= mem[{win, OFF_W'(j)}] & buf_data[j];
      end
    end
  end

  assign rd_data = mem[rd_addr];

  assert_commit_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> buf_valid != '0);
endmodule

// File: rtl/wbp_seq.sv
module wbp_seq #(
  parameter int AW            = 7,
  parameter int DW            = 16,
  parameter int BUF_WORDS     = 32,
  parameter int COMMIT_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          blk_lock,
  input  logic          supply_ok,
  output logic [7:0]    status,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int OFF_W = $clog2(BUF_WORDS);
  localparam int WIN_W = AW - OFF_W;

  logic                 buf_clr, buf_we, commit_go;
  logic [WIN_W-1:0]     win;
  logic [DW-1:0]        buf_data [BUF_WORDS];
  logic [BUF_WORDS-1:0] buf_valid;

  wbp_ctrl #(.AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS), .COMMIT_CYCLES(COMMIT_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .blk_lock(blk_lock), .supply_ok(supply_ok), .buf_clr(buf_clr), .buf_we(buf_we),
    .commit_go(commit_go), .win(win), .status(status)
  );

  wbp_buffer #(.DW(DW), .BUF_WORDS(BUF_WORDS)) u_buffer (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .off(wr_addr[OFF_W-1:0]),
    .wdata(wr_data), .buf_data(buf_data), .buf_valid(buf_valid)
  );

  wbp_array #(.AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit_go), .win(win), .buf_data(buf_data),
    .buf_valid(buf_valid), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/wbp_seq_bench.sv
module wbp_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7, DW = 16, NB = 32, CYC = 8;

  logic          clk, rst_n, wr_en, blk_lock, supply_ok;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic [7:0]    status;

  wbp_seq #(.AW(AW), .DW(DW), .BUF_WORDS(NB), .COMMIT_CYCLES(CYC)) u_wbp_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .blk_lock(blk_lock), .supply_ok(supply_ok), .status(status),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, fails = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference: 0 idle, 1 count, 2 load, 3 confirm, 4 commit
  int            mst, mrem, mwin, mbusy;
  bit            mf, ms, ml;
  logic [DW-1:0] marr [1 << AW];
  logic [DW-1:0] pend [int];

  function automatic logic [7:0] mstatus();
    return {mst != 4, 2'b00, mf, ms, 1'b0, ml, 1'b0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; mrem = 0; mwin = 0; mbusy = 0; mf = 0; ms = 0; ml = 0;
      for (int i = 0; i < (1 << AW); i++) marr[i] = '1;
      pend.delete();
    end else begin
      case (mst)
        0: if (wr_en) begin
          if (wr_data[7:0] == 8'hE8) mst = 1;
          else if (wr_data[7:0] == 8'h50) begin mf = 0; ms = 0; ml = 0; end
        end
        1: if (wr_en) begin
          if (int'(wr_data) > NB - 1) begin mf = 1; mst = 0; end
          else begin
            mrem = int'(wr_data) + 1; mwin = int'(wr_addr) / NB; pend.delete(); mst = 2;
          end
        end
        2: if (wr_en) begin
          if (int'(wr_addr) / NB != mwin) begin mf = 1; mst = 0; end
          else begin
            pend[int'(wr_addr) % NB] = wr_data;
            mrem--;
            if (mrem == 0) mst = 3;
          end
        end
        3: if (wr_en) begin
          if (wr_data[7:0] == 8'hD0) begin
            if (blk_lock) ml = 1;
            if (!supply_ok) ms = 1;
            if (!blk_lock && supply_ok) begin mbusy = CYC; mst = 4; end
            else mst = 0;
          end else begin mf = 1; mst = 0; end
        end
        default: begin
          if (mbusy == 1) begin
            foreach (pend[k]) marr[mwin * NB + k] = marr[mwin * NB + k] & pend[k];
            mst = 0;
          end else mbusy--;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(status == mstatus(), "R6 status vs model", status, mstatus());
      chk(rd_data == marr[rd_addr], "R7 array vs model", rd_data, marr[rd_addr]);
    end
  end

  task automatic put(input int a, input int d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expect_status(input logic [7:0] exp, input string req);
    chk(status == exp, req, status, exp);
  endtask

  task automatic expect_word(input int a, input logic [DW-1:0] exp, input string req);
    rd_addr = AW'(a); #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    blk_lock = 1'b0; supply_ok = 1'b1; rd_addr = '0;
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1; #1;
    expect_status(8'h80, "R1 reset status");
    expect_word(77, 16'hFFFF, "R1 erased array");

    // R2 setup, then four words in window 1
    put(40, 16'h00E8);
    expect_status(8'h80, "R2 buffer available after setup");
    put(33, 3);
    put(33, 16'h1234); put(34, 16'h00FF); put(40, 16'hA5A5); put(63, 16'h0F0F);
    put(33, 16'h00D0);
    expect_status(8'h00, "R6 busy after confirm");
    wait_cyc(CYC - 3);
    expect_status(8'h00, "R6 still busy");
    wait_cyc(4);
    expect_status(8'h80, "R6 ready after commit");
    expect_word(33, 16'h1234, "R7 word programmed");
    expect_word(63, 16'h0F0F, "R7 last window word");
    expect_word(35, 16'hFFFF, "R7 unwritten offset untouched");

    // R7 AND merge on reprogram
    put(0, 16'h00E8); put(33, 0); put(33, 16'hFF00); put(33, 16'h00D0);
    wait_cyc(CYC + 1);
    expect_word(33, 16'h1200, "R7 AND merge");

    // full 32-word buffer in window 2
    put(0, 16'h00E8); put(64, 31);
    for (int i = 0; i < NB; i++) put(64 + i, 16'h1000 + i);
    put(64, 16'h00D0);
    wait_cyc(CYC + 1);
    expect_word(64, 16'h1000, "R7 full buffer first");
    expect_word(95, 16'h101F, "R7 full buffer last");

    // R3 oversize count
    put(0, 16'h00E8); put(96, 32);
    expect_status(8'h90, "R3 oversize count fail");
    put(0, 16'h0050);
    expect_status(8'h80, "R10 clear status");

    // R4 out-of-window data
    put(0, 16'h00E8); put(96, 1); put(96, 16'h0000); put(32, 16'h0000);
    expect_status(8'h90, "R4 window abort");
    put(96, 16'h00D0);
    expect_word(96, 16'hFFFF, "R4 array untouched");
    put(0, 16'h0050);

    // R5 wrong confirm
    put(0, 16'h00E8); put(100, 0); put(100, 16'h0000); put(100, 16'h00FF);
    expect_status(8'h90, "R5 bad confirm fail");
    expect_word(100, 16'hFFFF, "R5 array untouched");
    put(0, 16'h0050);

    // R8 locked target
    blk_lock = 1'b1;
    put(0, 16'h00E8); put(101, 0); put(101, 16'h0000); put(101, 16'h00D0);
    expect_status(8'h82, "R8 lock error");
    wait_cyc(CYC + 1);
    expect_word(101, 16'hFFFF, "R8 array untouched");
    blk_lock = 1'b0;
    put(0, 16'h0050);

    // R9 invalid supply
    supply_ok = 1'b0;
    put(0, 16'h00E8); put(102, 0); put(102, 16'h0000); put(102, 16'h00D0);
    expect_status(8'h88, "R9 supply error");
    wait_cyc(CYC + 1);
    expect_word(102, 16'hFFFF, "R9 array untouched");
    supply_ok = 1'b1;
    put(0, 16'h0050);
    expect_status(8'h80, "R10 clear after supply error");

    // R11 writes during commit ignored
    put(0, 16'h00E8); put(110, 0); put(110, 16'h0000); put(110, 16'h00D0);
    put(0, 16'h00E8);
    put(111, 16'h0000);
    wait_cyc(CYC);
    expect_status(8'h80, "R11 ready after busy writes");
    put(0, 32);
    expect_status(8'h80, "R11 setup during commit not latched");
    expect_word(110, 16'h0000, "R11 commit completed");
    expect_word(111, 16'hFFFF, "R11 busy data write ignored");

    wait_cyc(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule